// File: doc/BRIEF.md
# Mixed-Mode Test Pattern Generator

This block produces stimulus for a combinational circuit under test in two phases that run back to back. A Fibonacci shift register with a fixed primitive feedback mask supplies one code word per pattern. During the first phase those words, optionally biased bit by bit, are applied directly as pseudorandom patterns. During the second phase the same register keeps stepping, and each word passes through a fixed combinational map that turns it into a precomputed deterministic vector.

The map is built around matched columns. Most output bits are straight or inverted copies of one register bit and cost no gates. Only the few unmatched bits need real logic. A pattern counter decides when the selector moves from the raw path to the mapped path and when the run ends. A start pulse launches a run. The block then emits one pattern per clock with a valid strobe, raises a completion flag together with the final pattern, and holds its outputs until the next start.

Top module: `mmtpg_gen`

## Requirements
- R1: The generator register is W bits wide (W at least 8). It loads SEED (nonzero) on reset and on an accepted start. Each emitted pattern advances it by one step: next = {s[W-2:0], parity(s AND TAP_MASK)}. It never holds all zeros.
- R2: A start pulse sampled while idle launches a run. Pattern k (counting from 0) appears on `pat_out` with `pat_valid` high in the second cycle after the start edge plus k cycles. It is computed from word k, which is SEED stepped k times.
- R3: Patterns 0 to PR_LEN-1 are pseudorandom. Bit i is x[i] | x[(i+1) mod W] when BIAS_HI[i] is 1. Otherwise it is x[i] & x[(i+1) mod W] when BIAS_LO[i] is 1. Otherwise it is x[i].
- R4: Patterns PR_LEN to PR_LEN+DET_LEN-1 are deterministic: y0=x0, y1=x1, y2=~x2, y3=x1, y4=~x0|x1, y5=x3, y6=~x4, y7=x6|(x5&~x7), and y[i]=x[i] for i of 8 and above.
- R5: The register is not reseeded at the phase change, so pattern PR_LEN is decoded from word PR_LEN.
- R6: A run emits exactly PR_LEN+DET_LEN patterns, with `pat_valid` high on consecutive cycles.
- R7: `done` rises in the same cycle as the final pattern. Afterwards `pat_valid` is 0, while `pat_out` and `done` hold until the next accepted start.
- R8: A start pulse during a run is ignored. The pattern sequence and its length are unchanged.
- R9: While reset is low, `pat_valid`, `done` and `pat_out` are 0. A run started after reset, or after a completed run, begins again from SEED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a run when idle |
| pat_valid | output | 1 | High in each cycle carrying a new pattern |
| pat_out | output | W | Applied test pattern |
| done | output | 1 | Run complete, held until the next start |

## Verification
The bench builds the block with an 8-bit register, PR_LEN of 6, DET_LEN of 10, one OR-biased bit (bit 4) and one AND-biased bit (bit 5). With these values both bias forms and every unmatched decoder bit are exercised within a 16-pattern run. The short phases put the phase change and the final pattern only a few cycles apart, so the same runs also cover a start pulse during the run, a reset in the middle of a run, and a restart after completion.

// File: rtl/mmtpg_pkg.sv
package mmtpg_pkg;
  typedef enum logic {
    PH_RAND = 1'b0,
    PH_DET  = 1'b1
  } phase_e;
endpackage

// File: rtl/mmtpg_lfsr.sv
module mmtpg_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAP_MASK = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] word
);
  function automatic logic [W-1:0] next_word(input logic [W-1:0] s);
    next_word = {s[W-2:0], ^(s & TAP_MASK)};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= SEED;
    else if (load)  word <= SEED;
    else if (step)  word <= next_word(word);
  end

  assert_lfsr_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word != '0);
  assert_lfsr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(word));
endmodule

// File: rtl/mmtpg_decoder.sv
module mmtpg_decoder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  // matched columns are bare wires; only bits 4 and 7 carry gates
  assign y[0] = x[0];
  assign y[1] = x[1];
  assign y[2] = ~x[2];
  assign y[3] = x[1];
  assign y[4] = ~x[0] | x[1];
  assign y[5] = x[3];
  assign y[6] = ~x[4];
  assign y[7] = x[6] | (x[5] & ~x[7]);

  generate
    for (genvar i = 8; i < W; i++) begin : g_pass
      assign y[i] = x[i];
    end
  endgenerate
endmodule

// File: rtl/mmtpg_switch.sv
module mmtpg_switch #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] BIAS_HI = '0,
  parameter logic [W-1:0] BIAS_LO = '0
) (
  input  mmtpg_pkg::phase_e phase,
  input  logic [W-1:0]      raw,
  input  logic [W-1:0]      dec,
  output logic [W-1:0]      pat
);
  logic [W-1:0] biased;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bias
      localparam int unsigned NB = (i + 1) % W;
      if (BIAS_HI[i]) begin : g_or
        assign biased[i] = raw[i] | raw[NB];
      end else if (BIAS_LO[i]) begin : g_and
        assign biased[i] = raw[i] & raw[NB];
      end else begin : g_wire
        assign biased[i] = raw[i];
      end
    end
  endgenerate

  always_comb begin
    pat = (phase == mmtpg_pkg::PH_DET) ? dec : biased;
  end
endmodule

// File: rtl/mmtpg_seq.sv
module mmtpg_seq #(
  parameter int unsigned PR_LEN = 6,
  parameter int unsigned DET_LEN = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              step,
  output logic              load,
  output logic              last_pat,
  output mmtpg_pkg::phase_e phase,
  output logic              done
);
  localparam int unsigned TOTAL = PR_LEN + DET_LEN;
  localparam int unsigned CNT_W = $clog2(TOTAL + 1);

  logic             running;
  logic [CNT_W-1:0] cnt;

  assign step     = running;
  assign load     = start && !running;
  assign last_pat = running && (cnt == CNT_W'(TOTAL - 1));
  assign phase    = (cnt >= CNT_W'(PR_LEN)) ? mmtpg_pkg::PH_DET : mmtpg_pkg::PH_RAND;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
    end else if (load) begin
      running <= 1'b1;
      done    <= 1'b0;
      cnt     <= '0;
    end else if (running) begin
      cnt <= cnt + 1'b1;
      if (last_pat) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt < CNT_W'(TOTAL));
  assert_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && running));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start && !last_pat) |=> running && cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/mmtpg_gen.sv
module mmtpg_gen #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAP_MASK = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01,
  parameter int unsigned PR_LEN = 6,
  parameter int unsigned DET_LEN = 10,
  parameter logic [W-1:0] BIAS_HI = 8'h10,
  parameter logic [W-1:0] BIAS_LO = 8'h20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         pat_valid,
  output logic [W-1:0] pat_out,
  output logic         done
);
  logic              step, load, last_pat;
  mmtpg_pkg::phase_e phase;
  logic [W-1:0]      lfsr_word, dec_word, sel_word;

  mmtpg_seq #(.PR_LEN(PR_LEN), .DET_LEN(DET_LEN)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .load(load),
    .last_pat(last_pat), .phase(phase), .done(done)
  );

  mmtpg_lfsr #(.W(W), .TAP_MASK(TAP_MASK), .SEED(SEED)) lfsr_i (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .word(lfsr_word)
  );

  mmtpg_decoder #(.W(W)) dec_i (.x(lfsr_word), .y(dec_word));

  mmtpg_switch #(.W(W), .BIAS_HI(BIAS_HI), .BIAS_LO(BIAS_LO)) sw_i (
    .phase(phase), .raw(lfsr_word), .dec(dec_word), .pat(sel_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_valid <= 1'b0;
      pat_out   <= '0;
    end else begin
      pat_valid <= step;
      if (step) pat_out <= sel_word;
    end
  end

  assert_det_invert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase == mmtpg_pkg::PH_DET) |=> pat_out[2] == ~$past(lfsr_word[2]));
  assert_last_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_pat |=> done && pat_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(pat_out) && !pat_valid && done);
endmodule

// File: tb/mmtpg_gen_tb.sv
module mmtpg_gen_tb_top;
  localparam int W = 8;
  localparam logic [W-1:0] TAPS = 8'hB8;
  localparam logic [W-1:0] SEED = 8'h01;
  localparam int PRL = 6;
  localparam int DETL = 10;
  localparam int TOTAL = PRL + DETL;
  localparam logic [W-1:0] BH = 8'h10;
  localparam logic [W-1:0] BL = 8'h20;
  // truth table of the low five deterministic bits, indexed by x[2:0] (R4)
  localparam logic [4:0] DEC_TT [8] = '{5'b10100, 5'b00101, 5'b11110, 5'b11111,
                                        5'b10000, 5'b00001, 5'b11010, 5'b11011};

  logic clk = 0, rst_n = 0, start = 0;
  logic pat_valid, done;
  logic [W-1:0] pat_out;
  int n_checks = 0, n_fail = 0;
  logic [W-1:0] words [TOTAL];

  always #4 clk = ~clk;

  mmtpg_gen #(.W(W), .TAP_MASK(TAPS), .SEED(SEED), .PR_LEN(PRL), .DET_LEN(DETL),
              .BIAS_HI(BH), .BIAS_LO(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_valid(pat_valid),
    .pat_out(pat_out), .done(done));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_step(input logic [W-1:0] s);
    logic fb = 1'b0;
    for (int b = 0; b < W; b++) if (TAPS[b]) fb = fb ^ s[b];
    return (s << 1) | W'(fb);
  endfunction

  function automatic logic [W-1:0] exp_pat(input int k);
    logic [W-1:0] x = words[k];
    logic [W-1:0] p;
    if (k < PRL) begin
      for (int i = 0; i < W; i++) begin
        if (BH[i])      p[i] = x[i] | x[(i + 1) % W];
        else if (BL[i]) p[i] = x[i] & x[(i + 1) % W];
        else            p[i] = x[i];
      end
    end else begin
      p = x;
      p[4:0] = DEC_TT[x[2:0]];
      p[5] = x[3];
      p[6] = !x[4];
      p[7] = !(!x[6] && !(x[5] && !x[7]));
    end
    return p;
  endfunction

  // one full run; a start pulse is injected at pattern index poke (negative: none)
  task automatic run_check(input string tag, input int poke);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check({"R2 idle before first ", tag}, W'(pat_valid), 0);
    for (int k = 0; k < TOTAL; k++) begin
      if (k == poke) start = 1;
      @(negedge clk) start = 0;
      check({"R6 valid ", tag}, W'(pat_valid), 1);
      if (k < PRL)       check({"R3 pseudorandom ", tag}, pat_out, exp_pat(k));
      else if (k == PRL) check({"R5 first decoded ", tag}, pat_out, exp_pat(k));
      else               check({"R4 decoded ", tag}, pat_out, exp_pat(k));
      check({"R7 done timing ", tag}, W'(done), W'(k == TOTAL - 1));
    end
    repeat (3) begin
      @(negedge clk);
      check({"R7 valid low after ", tag}, W'(pat_valid), 0);
      check({"R7 hold pattern ", tag}, pat_out, exp_pat(TOTAL - 1));
      check({"R7 done held ", tag}, W'(done), 1);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    words[0] = SEED;
    for (int k = 1; k < TOTAL; k++) words[k] = model_step(words[k-1]);
    for (int k = 0; k < TOTAL; k++) begin
      n_checks++;
      if (words[k] == '0) begin
        n_fail++;
        $display("FAIL R1 model word actual=%h expected=nonzero", words[k]);
      end
    end

    repeat (3) @(negedge clk);
    check("R9 reset valid", W'(pat_valid), 0);
    check("R9 reset done", W'(done), 0);
    check("R9 reset pattern", pat_out, 0);
    rst_n = 1;
    @(negedge clk);
    check("R2 idle no start", W'(pat_valid), 0);

    run_check("run1", -1);
    run_check("R9 restart", -1);
    run_check("R8 start mid-run", 4);
    run_check("R8 start at boundary", PRL);

    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (5) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R9 mid-run reset valid", W'(pat_valid), 0);
    check("R9 mid-run reset done", W'(done), 0);
    check("R9 mid-run reset pattern", pat_out, 0);
    rst_n = 1;
    run_check("R9 after reset", -1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule